// File: doc/BRIEF.md
# Absolute Credit Flow Controller (Sender Side)

This block sits at the transmit end of a link and decides, cycle by cycle, whether the next packet may start. The far end owns a receive buffer carved into fixed 64-byte blocks. From time to time it sends a credit update. That update is the running total of blocks the sender may have put on the link since the link came up, not an increment. The sender keeps its own running total of blocks sent. It lets a packet go only when the whole packet, rounded up to whole blocks, fits in the gap between that total and the latest advertised limit.

Both totals are 12-bit and wrap modulo 4096. The free space is therefore taken as the limit minus the sent count, modulo 4096. A difference in the upper half of that range means the limit lies behind the counter, and no credit is available. A lost or repeated update costs nothing lasting, because the next update restates the full figure. Between updates the block keeps granting from the last limit it holds.

A request is a one-cycle strobe with a byte length. The grant comes back combinationally in the same cycle. On the next clock edge the sent counter advances by the packet's cost in blocks.

Top module: `afc_credit_tx`

## Requirements
- R1: After reset the blocks-sent counter reads 0 and the held limit is 0, so every request is refused until an update raises the limit.
- R2: A packet of N bytes costs ceil(N/64) blocks; a zero-byte request is costed as one block.
- R3: With `reqValid` high, `grant` is high in that same cycle exactly when avail = (limit - blocksSent) mod 4096 satisfies cost <= avail < 2048; an exact fit is granted.
- R4: After a granted cycle, `blocksSent` equals its previous value plus the cost, modulo 4096, from the next rising edge on.
- R5: With `reqValid` low, `grant` is low and `blocksSent` does not change.
- R6: An update replaces the held limit; repeating an update with the same value adds no credit.
- R7: When `updValid` and `reqValid` are high in the same cycle, the grant decision uses the new `updLimit` against the counter value from before that cycle's grant.
- R8: When the limit lies 2048 or more blocks "ahead" modulo 4096 (that is, behind the counter), no request is granted.
- R9: Costs and limits that carry the counter past 4095 are handled modulo 4096, and granting continues correctly after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Packet start request for this cycle |
| reqBytes | input | 16 | Byte length of the requested packet |
| updValid | input | 1 | Credit update present this cycle |
| updLimit | input | 12 | Absolute block limit carried by the update |
| grant | output | 1 | Packet may start this cycle (combinational) |
| blocksSent | output | 12 | Running count of blocks granted, mod 4096 |

## Verification
The properties assume that `reqBytes` and `updLimit` are stable and defined whenever their strobes are high. They also assume that the link partner never advertises a limit more than 2047 blocks past the counter it has actually seen. The stimulus drives every input at the falling edge and holds it across the rising edge. Every limit it sends that is meant to be usable stays inside that window. It deliberately sends limits behind the counter only to confirm refusal. The packet lengths stay below 65536 bytes, so no cost can exceed 1024 blocks.

// File: rtl/afc_pkg.sv
package afc_pkg;

  // Strobes from the decision logic into the counters and limit register.
  typedef struct packed {
    logic grant;      // advance the sent counter by this cycle's cost
    logic loadLimit;  // capture the incoming absolute limit
  } afcStrobe_t;

endpackage

// File: rtl/afc_cost.sv
// Converts a byte length into a block cost, rounding up; zero bytes cost one block.
module afc_cost #(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 12,
  parameter int BLK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             checkEn,
  input  logic [LEN_W-1:0] reqBytes,
  output logic [CNT_W-1:0] cost
);

  localparam int SHIFT = $clog2(BLK_BYTES);
  localparam int WIDE  = CNT_W + SHIFT + 1;

  logic [LEN_W-1:0] wholeBlocks;
  logic             partBlock;
  logic [CNT_W-1:0] rawCost;

  generate
    if (SHIFT == 0) begin : g_byteBlocks
      assign wholeBlocks = reqBytes;
      assign partBlock   = 1'b0;
    end else begin : g_wideBlocks
      assign wholeBlocks = reqBytes >> SHIFT;
      assign partBlock   = |reqBytes[SHIFT-1:0];
    end
  endgenerate

  always_comb begin
    rawCost = CNT_W'(wholeBlocks) + CNT_W'(partBlock);
    cost    = (rawCost == '0) ? CNT_W'(1) : rawCost;
  end

  // R2: the cost covers the bytes and leaves less than one spare block.
  p_cost_round_r2: assert property (@(posedge clk) disable iff (!rst_n)
    checkEn |-> ((WIDE'(cost) * WIDE'(BLK_BYTES) >= WIDE'(reqBytes)) &&
                 ((reqBytes == '0) ||
                  ((WIDE'(cost) - WIDE'(1)) * WIDE'(BLK_BYTES) < WIDE'(reqBytes)))));

endmodule

// File: rtl/afc_datapath.sv
// Holds the absolute limit and the running sent count; reports whether the request fits.
module afc_datapath
  import afc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 12,
  parameter int BLK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqBytes,
  input  logic             updValid,
  input  logic [CNT_W-1:0] updLimit,
  input  afcStrobe_t       strobe,
  output logic             fits,
  output logic [CNT_W-1:0] blocksSent
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] limitQ;
  logic [CNT_W-1:0] sentQ;
  logic [CNT_W-1:0] cost;
  logic [CNT_W-1:0] effLimit;
  logic [CNT_W-1:0] avail;

  afc_cost #(
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W),
    .BLK_BYTES(BLK_BYTES)
  ) u_cost (
    .clk     (clk),
    .rst_n   (rst_n),
    .checkEn (reqValid),
    .reqBytes(reqBytes),
    .cost    (cost)
  );

  // An update in the same cycle is compared against the pre-grant count.
  always_comb begin
    effLimit = updValid ? updLimit : limitQ;
    avail    = effLimit - sentQ;
    fits     = (avail >= cost) && (avail < HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limitQ <= '0;
      sentQ  <= '0;
    end else begin
      if (strobe.loadLimit) limitQ <= updLimit;
      if (strobe.grant)     sentQ  <= sentQ + cost;
    end
  end

  assign blocksSent = sentQ;

  // R4: a grant advances the count by exactly the cost.
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.grant |=> (sentQ == CNT_W'($past(sentQ) + $past(cost))));

  // R5: no grant, no movement.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.grant |=> $stable(sentQ));

  // R6: the held limit is the last update, not an accumulation.
  p_absolute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    updValid |=> (limitQ == $past(updLimit)));

  // R8: after a grant the count never overtakes the limit.
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.grant |=> (CNT_W'(limitQ - sentQ) < HALF));

endmodule

// File: rtl/afc_ctrl.sv
// Turns the request, the update and the fit verdict into strobes.
module afc_ctrl
  import afc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       updValid,
  input  logic       fits,
  output afcStrobe_t strobe,
  output logic       grant
);

  always_comb begin
    strobe.grant     = reqValid && fits;
    strobe.loadLimit = updValid;
  end

  assign grant = strobe.grant;

  // R5: a grant only ever answers a request.
  p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> reqValid);

  // R3: a fitting request is never left waiting.
  p_fit_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && fits) |-> grant);

endmodule

// File: rtl/afc_credit_tx.sv
module afc_credit_tx
  import afc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 12,
  parameter int BLK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqBytes,
  input  logic             updValid,
  input  logic [CNT_W-1:0] updLimit,
  output logic             grant,
  output logic [CNT_W-1:0] blocksSent
);

  afcStrobe_t strobe;
  logic       fits;

  afc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .updValid(updValid),
    .fits    (fits),
    .strobe  (strobe),
    .grant   (grant)
  );

  afc_datapath #(
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W),
    .BLK_BYTES(BLK_BYTES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqBytes  (reqBytes),
    .updValid  (updValid),
    .updLimit  (updLimit),
    .strobe    (strobe),
    .fits      (fits),
    .blocksSent(blocksSent)
  );

endmodule

// File: tb/afc_credit_tx_tb.sv
module afc_credit_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqBytes = '0;
  logic        updValid = 1'b0;
  logic [11:0] updLimit = '0;
  logic        grant;
  logic [11:0] blocksSent;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  afc_credit_tx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqBytes  (reqBytes),
    .updValid  (updValid),
    .updLimit  (updLimit),
    .grant     (grant),
    .blocksSent(blocksSent)
  );

  // tag[4] req[1] bytes[16] upd[1] limit[12] expGrant[1] expSent[12]
  localparam int NV = 18;
  localparam logic [46:0] VEC [NV] = '{
    {4'd1, 1'b1, 16'd64,    1'b0, 12'd0,    1'b0, 12'd0},    // R1 refused before any update
    {4'd6, 1'b0, 16'd0,     1'b1, 12'd10,   1'b0, 12'd0},    // R6 load limit 10
    {4'd3, 1'b1, 16'd64,    1'b0, 12'd0,    1'b1, 12'd1},    // R3 one block
    {4'd2, 1'b1, 16'd65,    1'b0, 12'd0,    1'b1, 12'd3},    // R2 65 bytes -> 2
    {4'd2, 1'b1, 16'd0,     1'b0, 12'd0,    1'b1, 12'd4},    // R2 zero bytes -> 1
    {4'd3, 1'b1, 16'd384,   1'b0, 12'd0,    1'b1, 12'd10},   // R3 exact fit of 6
    {4'd3, 1'b1, 16'd1,     1'b0, 12'd0,    1'b0, 12'd10},   // R3 no space left
    {4'd6, 1'b1, 16'd1,     1'b1, 12'd10,   1'b0, 12'd10},   // R6 repeat adds nothing
    {4'd7, 1'b1, 16'd640,   1'b1, 12'd20,   1'b1, 12'd20},   // R7 same-cycle update used
    {4'd5, 1'b0, 16'd64,    1'b0, 12'd0,    1'b0, 12'd20},   // R5 idle
    {4'd8, 1'b1, 16'd64,    1'b1, 12'd5,    1'b0, 12'd20},   // R8 limit behind counter
    {4'd3, 1'b1, 16'd65535, 1'b1, 12'd2000, 1'b1, 12'd1044}, // R3 max-size packet
    {4'd3, 1'b1, 16'd65535, 1'b1, 12'd3044, 1'b1, 12'd2068}, // R3 again
    {4'd3, 1'b1, 16'd65535, 1'b1, 12'd4000, 1'b1, 12'd3092}, // R3 again
    {4'd9, 1'b1, 16'd65535, 1'b1, 12'd1000, 1'b1, 12'd20},   // R9 counter wraps
    {4'd9, 1'b1, 16'd64,    1'b0, 12'd0,    1'b1, 12'd21},   // R9 after wrap
    {4'd9, 1'b1, 16'd62656, 1'b0, 12'd0,    1'b1, 12'd1000}, // R9 fill to limit
    {4'd3, 1'b1, 16'd64,    1'b0, 12'd0,    1'b0, 12'd1000}  // R3 full again
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive at the falling edge, check grant mid-low phase, count after the rising edge.
  task automatic step(input string tag, input bit rq, input int nb, input bit up,
                      input int lim, input bit eg, input int es);
    @(negedge clk);
    reqValid = rq;
    reqBytes = 16'(nb);
    updValid = up;
    updLimit = 12'(lim);
    #5;
    check(tag, "grant", int'(grant), int'(eg));
    @(posedge clk);
    #1;
    check(tag, "blocksSent", int'(blocksSent), es);
    reqValid = 1'b0;
    updValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "blocksSent after reset", int'(blocksSent), 0);

    for (int i = 0; i < NV; i++) begin
      step($sformatf("R%0d", VEC[i][46:43]), VEC[i][42], int'(VEC[i][41:26]),
           VEC[i][25], int'(VEC[i][24:13]), VEC[i][12], int'(VEC[i][11:0]));
    end

    // R1: reset mid-run clears count and limit.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "blocksSent in reset", int'(blocksSent), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 1'b1, 64, 1'b0, 0, 1'b0, 0);

    // R7: old limit would allow, new limit forbids.
    step("R7", 1'b0, 0,   1'b1, 5, 1'b0, 0);
    step("R7", 1'b1, 320, 1'b1, 3, 1'b0, 0);
    step("R7", 1'b1, 192, 1'b0, 0, 1'b1, 3);
    // R6: resending the same limit gives no extra room.
    step("R6", 1'b1, 64,  1'b1, 3, 1'b0, 3);
    // R5: length on the bus without a request does nothing.
    step("R5", 1'b0, 64,  1'b1, 9, 1'b0, 3);
    step("R4", 1'b1, 129, 1'b0, 0, 1'b1, 6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule